// File: doc/BRIEF.md
# Sine-Breathing LED PWM Generator

This block makes one LED fade up and down smoothly. It follows a sine-shaped brightness curve and runs entirely on the single system clock. It has no slow clock and no divided clock. A fractional phase accumulator adds a run-time increment word on every clock edge. The top bits of the accumulator select an entry of a 256-point sine table. The table is computed when the design is elaborated. The sample read from the table becomes the duty cycle of an 8-bit pulse-width modulator, and the modulator output drives the LED.

The breathing rate is f_clk × increment / 2^26. Because the increment is a fractional phase step, any average rate down to one count is reachable, including rates that are not a power of two. The increment passes through a register, so software or a neighbouring block may change it at any time. A change never resets the phase. A new duty value is taken only at the start of a PWM period, so no period is ever cut short.

Top module: `led_breath_pwm`

## Requirements
- R1: The phase accumulator is 26 bits wide. On every clock edge it adds the registered increment and wraps modulo 2^26, with no enable. The low (fractional) bits carry into the address bits.
- R2: The increment input is captured in a register one cycle before the accumulator uses it. Changing the increment keeps the accumulated phase, so the phase reached is the sum of all increments applied.
- R3: The table address is accumulator bits 25 down to 18. The sample is read from the table synchronously, one cycle after the address.
- R4: Table entry k holds 128 + round(127 × sin(2πk/256)), an 8-bit offset-binary value. For example, entry 0 is 128, entry 32 is 218, entry 64 is 255 and entry 192 is 1.
- R5: The PWM counter is 8 bits and free-running. For a latched duty D, the output is high for exactly D of every 256 cycles.
- R6: A new duty value is latched only when the PWM counter wraps to 0. The output goes high only at the start of a period, so each period has a single contiguous high pulse.
- R7: Reset is synchronous and active high. It clears the accumulator, the PWM counter and the latched duty, and holds the output low. The output stays low for the first PWM period after reset.
- R8: An increment of zero freezes the phase, so the brightness holds at the current table entry for as long as the increment stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses it |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 26 | Phase increment added to the accumulator on each cycle |
| pwm_o | output | 1 | Registered PWM pulse to the LED |

## Verification
The bench builds the block with its default parameters: a 26-bit accumulator, an 8-bit address and an 8-bit duty. At these widths a single increment of 2^18 moves the phase by exactly one table entry. An increment of 2^17 moves it by half an entry, so short bursts of increment place the phase on a chosen entry and then freeze it there. Bursts made of fractional steps, of mixed step sizes and of more than a full turn check the carry from the fractional bits, phase preservation across increment changes, and wrap-around. The high-time count of a frozen 256-cycle period then checks table entries at the crest, the trough and the zero crossing against a sine computed in the bench.

// File: rtl/breath_pkg.sv
package breath_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Sine by Taylor series after reducing the angle into [-pi, pi].
  function automatic real series_sin(input real ang);
    real x;
    real term;
    real sum;
    x = ang;
    if (x > TWO_PI / 2.0) x = x - TWO_PI;
    term = x;
    sum  = x;
    for (int n = 1; n <= 10; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Offset-binary sine point: mid + round(amp * sin(2*pi*k/n)).
  function automatic int sine_point(input int k, input int n,
                                    input int mid, input int amp);
    real v;
    v = real'(mid) + real'(amp) * series_sin(TWO_PI * real'(k) / real'(n));
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0;
      acc_q <= '0;
    end else begin
      inc_q <= inc_i;
      acc_q <= acc_q + inc_q;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int DEPTH = 2 ** ADDR_W;
  localparam int MID   = 2 ** (DATA_W - 1);
  localparam int AMP   = MID - 1;

  typedef logic [DEPTH*DATA_W-1:0] table_t;

  function automatic table_t build_table();
    table_t t;
    t = '0;
    for (int k = 0; k < DEPTH; k++) begin
      t[k*DATA_W +: DATA_W] = DATA_W'(breath_pkg::sine_point(k, DEPTH, MID, AMP));
    end
    return t;
  endfunction

  localparam table_t TABLE = build_table();

  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign rom[g] = TABLE[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    data_o <= rom[addr_i];
  end

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              pwm_o
);

  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_q;
  logic              pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) duty_q <= duty_i;
      pwm_q <= (cnt_q < duty_q);
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign pwm_o  = pwm_q;

endmodule

// File: rtl/led_breath_pwm.sv
module led_breath_pwm #(
  parameter int ACC_W  = 26,
  parameter int ADDR_W = 8,
  parameter int DUTY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_i,
  output logic             pwm_o
);

  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DUTY_W-1:0] sample;
  logic [DUTY_W-1:0] pwm_cnt;
  logic [DUTY_W-1:0] duty_q;

  phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .inc_i (inc_i),
    .acc_o (acc_q)
  );

  assign tbl_addr = acc_q[ACC_W-1 -: ADDR_W];

  sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DUTY_W)) u_rom (
    .clk    (clk),
    .addr_i (tbl_addr),
    .data_o (sample)
  );

  pwm_core #(.DUTY_W(DUTY_W)) u_pwm (
    .clk    (clk),
    .rst    (rst),
    .duty_i (sample),
    .cnt_o  (pwm_cnt),
    .duty_o (duty_q),
    .pwm_o  (pwm_o)
  );

endmodule

// File: rtl/led_breath_chk.sv
module led_breath_chk #(
  parameter int ACC_W  = 26,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  inc_i,
  input logic              pwm_o,
  input logic [ACC_W-1:0]  acc,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] duty
);

  logic [1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  // R1, R2: the phase grows by the increment seen at the input two edges earlier
  a_r1_acc_step: assert property (@(posedge clk) disable iff (rst)
    (live_q == 2'd3) |-> (acc == ACC_W'($past(acc) + $past(inc_i, 2))));

  // R8: a zero increment, once registered, leaves the phase unchanged
  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    (live_q == 2'd3 && $past(inc_i, 2) == '0) |-> $stable(acc));

  // R6: the duty changes only as the counter starts a new period
  a_r6_duty_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty) |-> (cnt == '0));

  // R6: the output rises only in the first slot of a period
  a_r6_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> (cnt == DUTY_W'(1)));

  // R7: reset leaves everything cleared and the output low
  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (!pwm_o && acc == '0 && cnt == '0 && duty == '0));

endmodule

bind led_breath_pwm led_breath_chk #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .inc_i (inc_i),
  .pwm_o (pwm_o),
  .acc   (acc_q),
  .cnt   (pwm_cnt),
  .duty  (duty_q)
);

// File: tb/tb_led_breath_pwm.sv
`timescale 1ns/1ps
module tb_led_breath_pwm;

  localparam int ACC_W = 26;
  localparam int STEP  = 1 << 18;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [ACC_W-1:0] inc_i = '0;
  logic             pwm_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  led_breath_pwm dut (
    .clk   (clk),
    .rst   (rst),
    .inc_i (inc_i),
    .pwm_o (pwm_o)
  );

  function automatic int exp_entry(input int k);
    real a;
    a = 6.283185307179586 * real'(k) / 256.0;
    return 128 + int'(127.0 * $sin(a));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst   = 1'b1;
    inc_i = '0;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic burst(input int val, input int n);
    inc_i = ACC_W'(val);
    cycles(n);
    inc_i = '0;
  endtask

  // Count high cycles and rising edges over one full period.
  task automatic measure(output int highs, output int rises);
    logic prev;
    highs = 0;
    rises = 0;
    prev  = pwm_o;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
      if (pwm_o && !prev) rises++;
      prev = pwm_o;
    end
  endtask

  task automatic settle_and_check(input string req, input int k);
    int h;
    int r;
    cycles(3 * 256 + 10);
    measure(h, r);
    check(req, h, exp_entry(k));
  endtask

  task automatic t_reset();
    int highs;
    @(negedge clk);
    rst = 1'b1;
    cycles(2);
    check("R7 low during reset", int'(pwm_o), 0);
    rst = 1'b0;
    highs = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
    check("R7 first period low", highs, 0);
  endtask

  task automatic t_entry0();
    do_reset();
    settle_and_check("R4 entry 0", 0);
  endtask

  task automatic t_crest();
    int h;
    int r;
    do_reset();
    burst(64 * STEP, 1);
    cycles(3 * 256 + 10);
    measure(h, r);
    check("R4 entry 64 crest", h, 255);
    check("R5 crest high count", h, exp_entry(64));
  endtask

  task automatic t_trough();
    int h;
    int r;
    do_reset();
    burst(192 * STEP, 1);
    cycles(3 * 256 + 10);
    measure(h, r);
    check("R4 entry 192 trough", h, 1);
    check("R6 single pulse at trough", r, 1);
  endtask

  task automatic t_steps();
    do_reset();
    burst(STEP, 3);
    settle_and_check("R1 three whole steps", 3);
  endtask

  task automatic t_fraction();
    do_reset();
    burst(STEP / 2 + 1, 2);
    settle_and_check("R1 fractional carry", 1);
  endtask

  task automatic t_mixed();
    do_reset();
    inc_i = ACC_W'(STEP / 2);
    cycles(1);
    inc_i = ACC_W'(3 * STEP / 2);
    cycles(1);
    inc_i = ACC_W'(20 * STEP);
    cycles(1);
    inc_i = '0;
    settle_and_check("R2 mixed increments keep phase", 22);
  endtask

  task automatic t_wrap();
    do_reset();
    burst(128 * STEP, 2);
    burst(5 * STEP, 1);
    settle_and_check("R1 wrap modulo 2^26", 5);
  endtask

  task automatic t_freeze_pulse();
    int h1;
    int r1;
    int h2;
    int r2;
    do_reset();
    burst(32 * STEP, 1);
    cycles(3 * 256 + 10);
    measure(h1, r1);
    check("R3 entry 32 via top bits", h1, exp_entry(32));
    cycles(1000);
    measure(h2, r2);
    check("R8 frozen brightness holds", h2, h1);
    check("R6 one rising edge per period", r2, 1);
  endtask

  initial begin
    t_reset();
    t_entry0();
    t_crest();
    t_trough();
    t_steps();
    t_fraction();
    t_mixed();
    t_wrap();
    t_freeze_pulse();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule